// File: doc/BRIEF.md
# I2C Byte-Command Master

This block is an I2C bus master that is stepped by software one phase at a time. A 16-bit command word either opens a transfer or moves one data byte. An open takes the form of a START, or of a repeated START while the bus is held, followed by the 7-bit target address and the direction bit. A data command sends one byte or receives one byte. The same word also carries the target address, the outgoing byte and the acknowledge policy.

Every address phase and every data phase ends with the same three actions. A master event flag is raised, the interrupt goes high, and SCL is held low. The engine then waits for the next command, and a command that clears the event releases it. A STOP command releases the bus. The SCL rate comes from a divisor register: each quarter of a bit lasts `divisor * QTR_UNIT` clocks. With `QTR_UNIT` clocks per 125 ns, a divisor of 2 MHz divided by the bus rate gives that rate, so a divisor of 20 gives 100 kHz.

Registers are written through `reg_wr`, `reg_addr` and `reg_wdata`, and they are read back combinationally on `reg_rdata`. Register offsets: status at 0x0, event at 0x1, received byte at 0x2, command at 0x4, divisor at 0xC.

Top module: `i2cm_engine`

## Requirements
- R1: After reset, SCL and SDA are released and `irq` is low. The status, event and received-byte registers read 0, and the divisor register reads 20.
- R2: A command with bit 0 (START) set, written while the engine is idle, generates START. The engine then shifts out bits 15:9 as the address, MSB first, with bit 2 as the read/write bit (1 = read). It samples the target's acknowledge into status bit 3 (1 = ACK).
- R3: At the end of every address or data phase, event bit 4 and `irq` go high. They stay high, with SCL held low, until software clears the event.
- R4: A command write with bit 7 set clears a pending event, and `irq` reads low on the next clock. Writing 0 to the event register (offset 0x1) also clears the event, but the bus stays held.
- R5: While the bus is held, a command with bit 7 set and bits 0, 1 and 2 clear sends bits 15:8 MSB first. The acknowledge from the target goes to status bit 3, and a NACK reads as 0.
- R6: While the bus is held, a command with bits 7 and 2 set receives one byte, MSB first, into the register at offset 0x2. If bit 3 is 1, the master pulls SDA low in the acknowledge slot. If bit 3 is 0, it leaves SDA released, which is a NACK. Status bit 3 echoes bit 3 of the command.
- R7: While the bus is held, a command with bits 0 and 7 set generates a repeated START and then an address phase.
- R8: While the bus is held, a command with bits 1 and 7 set (and bit 0 clear) generates STOP and leaves both lines released.
- R9: SCL stays high for two quarters, that is 2 × divisor × `QTR_UNIT` clocks. A divisor of 0 acts as 1.
- R10: SDA changes while SCL is high only to form START, repeated START or STOP.
- R11: A data command written while the engine is idle is ignored: SCL is not driven and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data (command word or register value) |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | High while a master event is pending |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The event flag and `irq` rise one clock after the final quarter tick of the acknowledge bit. The clear from a command or an event-register write shows one clock after the write edge. SCL edges follow the quarter tick that owns them by one register stage. All inputs are driven and all outputs sampled on the falling edge. Phase completion is found by polling `irq` with a cycle bound. The irq clear is checked at the first falling edge after the write. Released lines after STOP are checked only after the three STOP quarters have certainly passed. SCL high time is counted in clocks between the observed edges.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int DIV_W = 8;
  localparam int CMD_W = 16;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_READ  = 2;
  localparam int CMD_ACKEN = 3;
  localparam int CMD_EVCLR = 7;

  localparam int STAT_ACK  = 3;
  localparam int EVT_MSTR  = 4;

  localparam logic [3:0] OFS_STATUS = 4'h0;
  localparam logic [3:0] OFS_EVENT  = 4'h1;
  localparam logic [3:0] OFS_RXBYTE = 4'h2;
  localparam logic [3:0] OFS_CMD    = 4'h4;
  localparam logic [3:0] OFS_DIV    = 4'hC;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_OPEN,
    SQ_SHIFT,
    SQ_HOLD,
    SQ_CLOSE
  } seq_state_e;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int DIV_W    = 8,
  parameter int QTR_UNIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restart,
  output logic             tick
);
  localparam int CNT_W = DIV_W + $clog2(QTR_UNIT + 1) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic [DIV_W-1:0] eff_div;

  always_comb begin
    eff_div = (divisor == '0) ? DIV_W'(1) : divisor;
    limit   = CNT_W'(eff_div) * CNT_W'(QTR_UNIT) - CNT_W'(1);
    tick    = (cnt_q == limit) && !restart;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go_open,
  input  logic       go_close,
  input  logic       go_byte,
  input  logic       rx_mode,
  input  logic       ack_en,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic       done,
  output logic       ack_seen,
  output logic [7:0] rx_byte,
  output logic       idle,
  output logic       held,
  output logic       framing
);
  seq_state_e state_q, state_d;
  logic [1:0] qtr_q, qtr_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d, rx_q, rx_d;
  logic       scl_q, scl_d, sda_q, sda_d;
  logic       rxm_q, rxm_d, acken_q, acken_d, ack_q, ack_d, done_q, done_d;

  always_comb begin
    state_d = state_q; qtr_d = qtr_q; bit_d = bit_q; sh_d = sh_q; rx_d = rx_q;
    scl_d = scl_q; sda_d = sda_q; rxm_d = rxm_q; acken_d = acken_q; ack_d = ack_q;
    done_d = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        scl_d = 1'b0; sda_d = 1'b0;
        if (go_open) begin
          state_d = SQ_OPEN; qtr_d = 2'd2; sh_d = tx_byte; rxm_d = 1'b0;
        end
      end
      SQ_HOLD: begin
        if (go_open) begin
          state_d = SQ_OPEN; qtr_d = 2'd0; sh_d = tx_byte; rxm_d = 1'b0;
        end else if (go_close) begin
          state_d = SQ_CLOSE; qtr_d = 2'd0;
        end else if (go_byte) begin
          state_d = SQ_SHIFT; qtr_d = 2'd0; bit_d = '0; sh_d = tx_byte;
          rxm_d = rx_mode; acken_d = ack_en;
        end
      end
      SQ_OPEN: if (tick) begin
        case (qtr_q)
          2'd0: begin sda_d = 1'b0; qtr_d = 2'd1; end
          2'd1: begin scl_d = 1'b0; qtr_d = 2'd2; end
          2'd2: begin sda_d = 1'b1; qtr_d = 2'd3; end
          default: begin
            scl_d = 1'b1; state_d = SQ_SHIFT; qtr_d = 2'd0; bit_d = '0;
          end
        endcase
      end
      SQ_SHIFT: if (tick) begin
        case (qtr_q)
          2'd0: begin
            sda_d = (bit_q == 4'd8) ? (rxm_q & acken_q) : (!rxm_q & !sh_q[7]);
            qtr_d = 2'd1;
          end
          2'd1: begin scl_d = 1'b0; qtr_d = 2'd2; end
          2'd2: begin
            if (bit_q != 4'd8) sh_d = {sh_q[6:0], sda_in};
            else               ack_d = rxm_q ? acken_q : !sda_in;
            qtr_d = 2'd3;
          end
          default: begin
            scl_d = 1'b1; qtr_d = 2'd0;
            if (bit_q == 4'd8) begin
              state_d = SQ_HOLD; done_d = 1'b1;
              if (rxm_q) rx_d = sh_q;
            end else begin
              bit_d = bit_q + 4'd1;
            end
          end
        endcase
      end
      SQ_CLOSE: if (tick) begin
        case (qtr_q)
          2'd0: begin sda_d = 1'b1; qtr_d = 2'd1; end
          2'd1: begin scl_d = 1'b0; qtr_d = 2'd2; end
          default: begin sda_d = 1'b0; state_d = SQ_IDLE; qtr_d = 2'd0; end
        endcase
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE; qtr_q <= '0; bit_q <= '0; sh_q <= '0; rx_q <= '0;
      scl_q <= 1'b0; sda_q <= 1'b0; rxm_q <= 1'b0; acken_q <= 1'b0;
      ack_q <= 1'b0; done_q <= 1'b0;
    end else begin
      state_q <= state_d; qtr_q <= qtr_d; bit_q <= bit_d; sh_q <= sh_d; rx_q <= rx_d;
      scl_q <= scl_d; sda_q <= sda_d; rxm_q <= rxm_d; acken_q <= acken_d;
      ack_q <= ack_d; done_q <= done_d;
    end
  end

  assign scl_pull = scl_q;
  assign sda_pull = sda_q;
  assign done     = done_q;
  assign ack_seen = ack_q;
  assign rx_byte  = rx_q;
  assign idle     = (state_q == SQ_IDLE);
  assign held     = (state_q == SQ_HOLD);
  assign framing  = (state_q == SQ_OPEN) || (state_q == SQ_CLOSE);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int QTR_UNIT  = 1,
  parameter int DIV_RESET = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [CMD_W-1:0] reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  logic [DIV_W-1:0] div_q, div_d;
  logic             evt_q, evt_d;
  logic             cmd_wr, evt_wr, div_wr;
  logic             go_open, go_close, go_byte, tick;
  logic             done, ack_seen, idle, held, framing;
  logic [7:0]       tx_byte, rx_byte;

  always_comb begin
    cmd_wr   = reg_wr && (reg_addr == OFS_CMD);
    evt_wr   = reg_wr && (reg_addr == OFS_EVENT);
    div_wr   = reg_wr && (reg_addr == OFS_DIV);
    go_open  = cmd_wr && reg_wdata[CMD_START] && (idle || (held && reg_wdata[CMD_EVCLR]));
    go_close = cmd_wr && held && reg_wdata[CMD_EVCLR] && reg_wdata[CMD_STOP] &&
               !reg_wdata[CMD_START];
    go_byte  = cmd_wr && held && reg_wdata[CMD_EVCLR] && !reg_wdata[CMD_START] &&
               !reg_wdata[CMD_STOP];
    tx_byte  = reg_wdata[CMD_START] ? {reg_wdata[15:9], reg_wdata[CMD_READ]} : reg_wdata[15:8];

    div_d = div_wr ? reg_wdata[DIV_W-1:0] : div_q;
    if (done)                                 evt_d = 1'b1;
    else if (cmd_wr && reg_wdata[CMD_EVCLR])  evt_d = 1'b0;
    else if (evt_wr && !reg_wdata[EVT_MSTR])  evt_d = 1'b0;
    else                                      evt_d = evt_q;

    case (reg_addr)
      OFS_STATUS: reg_rdata = 8'(ack_seen) << STAT_ACK;
      OFS_EVENT:  reg_rdata = 8'(evt_q) << EVT_MSTR;
      OFS_RXBYTE: reg_rdata = rx_byte;
      OFS_DIV:    reg_rdata = div_q;
      default:    reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_RESET);
      evt_q <= 1'b0;
    end else begin
      div_q <= div_d;
      evt_q <= evt_d;
    end
  end

  i2cm_qtick #(.DIV_W(DIV_W), .QTR_UNIT(QTR_UNIT)) u_tick (
    .clk(clk), .rst_n(rst_n), .divisor(div_q),
    .restart(go_open || go_close || go_byte), .tick(tick)
  );

  i2cm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .go_open(go_open), .go_close(go_close), .go_byte(go_byte),
    .rx_mode(reg_wdata[CMD_READ]), .ack_en(reg_wdata[CMD_ACKEN]),
    .tx_byte(tx_byte), .sda_in(sda_in),
    .scl_pull(scl_oe), .sda_pull(sda_oe), .done(done), .ack_seen(ack_seen),
    .rx_byte(rx_byte), .idle(idle), .held(held), .framing(framing)
  );

  assign irq = evt_q;
endmodule

// File: rtl/i2cm_engine_chk.sv
module i2cm_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        irq,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        framing
);
  logic cmd_clr, evt_clr;
  assign cmd_clr = reg_wr && (reg_addr == 4'h4) && reg_wdata[7];
  assign evt_clr = reg_wr && (reg_addr == 4'h1) && !reg_wdata[4];

  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_oe); // R3

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cmd_clr && !evt_clr) |=> irq); // R3

  AST_CMD_CLEARS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && cmd_clr) |=> !irq); // R4

  AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && !$stable(sda_oe)) |-> $past(framing)); // R10
endmodule

bind i2cm_engine i2cm_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .framing(framing)
);

// File: tb/tb_i2cm_engine.sv
module tb_i2cm_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr, sda_in, irq, scl_oe, sda_oe;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [7:0]  reg_rdata;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  i2cm_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Target model on the wired-AND bus: address 0x3A, NACKs written 0xFF,
  // returns 0xC5, 0xC6, ... on reads.
  logic s_drive = 1'b0;
  wire  scl = ~scl_oe;
  wire  sda = ~(sda_oe | s_drive);
  assign sda_in = sda;
  int         bitn = 0, wn = 0, mn = 0;
  logic [7:0] sr = '0, rdb = 8'hC5;
  logic       sel = 0, reading = 0, in_addr = 0;
  logic [7:0] wlog [0:3];
  logic       mack [0:3];

  always @(negedge sda) if (scl === 1'b1) begin
    bitn = 0; in_addr = 1; sel = 0; reading = 0; s_drive = 0;
  end
  always @(posedge sda) if (scl === 1'b1) begin
    sel = 0; reading = 0; s_drive = 0;
  end
  always @(posedge scl) begin
    if (bitn < 8) sr = {sr[6:0], sda};
    else if (sel && reading && !in_addr) begin
      if (mn < 4) begin mack[mn] = !sda; mn++; end
      if (sda) reading = 0; else rdb = rdb + 8'd1;
    end
    bitn++;
  end
  always @(negedge scl) begin
    if (bitn == 8) begin
      if (in_addr) begin
        sel = (sr[7:1] == 7'h3A); reading = sr[0]; s_drive = sel;
      end else if (sel && !reading) begin
        if (wn < 4) begin wlog[wn] = sr; wn++; end
        s_drive = (sr != 8'hFF);
      end else s_drive = 0;
    end else if (bitn == 9) begin
      bitn = 0; in_addr = 0; s_drive = sel && reading && !rdb[7];
    end else if (bitn >= 1 && bitn <= 7 && sel && reading && !in_addr)
      s_drive = !rdb[7-bitn];
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
  endtask

  // {wait_evt, chk_data, exp_ack, exp_data[7:0], cmd[15:0]}
  localparam logic [26:0] VEC [0:8] = '{
    {1'b1, 1'b0, 1'b1, 8'h00, 16'h7481},  // open write 0x3A
    {1'b1, 1'b0, 1'b1, 8'h00, 16'hA580},  // write 0xA5, ACK
    {1'b1, 1'b0, 1'b0, 8'h00, 16'hFF80},  // write 0xFF, NACK
    {1'b1, 1'b0, 1'b1, 8'h00, 16'h7485},  // repeated open, read
    {1'b1, 1'b1, 1'b1, 8'hC5, 16'h008C},  // read with ACK
    {1'b1, 1'b1, 1'b0, 8'hC6, 16'h0084},  // last read, NACK
    {1'b0, 1'b0, 1'b0, 8'h00, 16'h0082},  // stop
    {1'b1, 1'b0, 1'b0, 8'h00, 16'h2281},  // open absent 0x11
    {1'b0, 1'b0, 1'b0, 8'h00, 16'h0082}   // stop
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic       held_bus;
    int         width;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {irq, scl_oe, sda_oe}, 3'b000);
    rd(4'h0, d); check("R1", d, 8'h00);
    rd(4'h1, d); check("R1", d, 8'h00);
    rd(4'h2, d); check("R1", d, 8'h00);
    rd(4'hC, d); check("R1", d, 8'd20);
    wr(4'hC, 16'h0001);

    // R11 data command while idle is ignored
    wr(4'h4, 16'hA580);
    width = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (scl_oe || irq) width++;
    end
    check("R11", width, 0);

    // Vector table
    held_bus = 0;
    for (int k = 0; k < 9; k++) begin
      logic [26:0] v;
      string       tag;
      v = VEC[k];
      if (v[0])              tag = held_bus ? "R7" : "R2";
      else if (v[1])         tag = "R8";
      else if (v[2])         tag = "R6";
      else                   tag = "R5";
      wr(4'h4, v[15:0]);
      if (held_bus) check("R4", irq, 1'b0);
      if (v[26]) begin
        wait_irq();
        check("R3", irq, 1'b1);
        repeat (10) @(negedge clk);
        check("R3", {irq, scl_oe}, 2'b11);
        rd(4'h1, d); check("R3", d, 8'h10);
        rd(4'h0, d); check(tag, d[3], v[24]);
        if (v[25]) begin rd(4'h2, d); check(tag, d, v[23:16]); end
        held_bus = 1;
      end else begin
        repeat (20) @(negedge clk);
        check(tag, {scl_oe, sda_oe, irq}, 3'b000);
        held_bus = 0;
      end
    end
    check("R5", wlog[0], 8'hA5);
    check("R5", wlog[1], 8'hFF);
    check("R6", mack[0], 1'b1);
    check("R6", mack[1], 1'b0);

    // R4 clearing through the event register keeps the bus held
    wr(4'h4, 16'h7481);
    wait_irq();
    wr(4'h1, 16'h0000);
    check("R4", {irq, scl_oe}, 2'b01);
    rd(4'h1, d); check("R4", d, 8'h00);
    wr(4'h4, 16'h0082);
    repeat (20) @(negedge clk);
    check("R8", {scl_oe, sda_oe}, 2'b00);

    // R9 SCL high time for divisor 3 and divisor 0
    for (int t = 0; t < 2; t++) begin
      logic [7:0] dv;
      dv = (t == 0) ? 8'd3 : 8'd0;
      wr(4'hC, {8'h00, dv});
      wr(4'h4, 16'h7481);
      for (int i = 0; i < 500 && !scl_oe; i++) @(negedge clk);
      for (int i = 0; i < 500 && scl_oe; i++) @(negedge clk);
      width = 0;
      for (int i = 0; i < 500 && !scl_oe; i++) begin @(negedge clk); width++; end
      check("R9", width, (t == 0) ? 6 : 2);
      wait_irq();
      wr(4'h4, 16'h0082);
      repeat (40) @(negedge clk);
    end
    finish_run();
  end
endmodule